// File: doc/BRIEF.md
# Protected Switch Fault and Sleep Controller

This block is the digital supervisor of a protected high-side power switch whose single input line carries two things: the PWM command from the host, and, while a fault is latched, a fault report that the switch sends back by pulling that same line low in a square-wave pattern. The controller follows the command level on its gate output. After a long continuous low on the line it drops into a low-power sleep state. On the next rising edge it wakes, holds the gate off through a power-on settling delay, and then lets the gate follow the line again.

Over-current and over-temperature flags latch the gate off at once, through the hard turn-off path rather than the slope-controlled one. A latched fault can only be cleared by letting the device fall asleep and stay asleep for a reset interval. The kind of fault is told apart by the frequency of the pull-down square wave. A supply-low flag blocks the gate for as long as it is asserted and needs no clearing. All intervals are counted in ticks of an external timing enable, and every incoming flag is brought into the clock domain through two flops.

Top module: `psw_sleep_ctrl`

## Requirements
- R1: After reset the block is asleep (`asleep`=1), with `gate_on`=0, `hard_off`=0, `diag_pull`=0, `flt_oc`=0 and `flt_ot`=0.
- R2: While asleep, a rising edge on the synchronised `pwm_in` wakes the block (`asleep` goes to 0). A high pulse lasting three clock cycles is enough.
- R3: After wake, `gate_on` stays 0 until `POR_TICKS` tick enables have been counted. Clock cycles in which `tick` is 0 do not advance this delay.
- R4: Once the power-on delay is over, with no fault latched and the supply flag clear, `gate_on` equals the synchronised level of `pwm_in`.
- R5: The block goes to sleep when `pwm_in` has been low for `SLEEP_TICKS` consecutive ticks. A low period that is shorter, followed by a high level, keeps it awake.
- R6: An over-current or over-temperature flag seen while awake latches `flt_oc` or `flt_ot`. While either is latched, `gate_on`=0 and `hard_off`=1, and both remain so after the flag itself goes away.
- R7: Latched faults clear only after the block has stayed asleep for `RST_TICKS` consecutive ticks. If it wakes before that, the faults stay latched.
- R8: While a fault is latched, `diag_pull` toggles every `OT_HALF_TICKS` ticks when `flt_ot` is set, and every `OC_HALF_TICKS` ticks otherwise. Over-temperature wins when both faults are latched. `diag_pull` is 1 in the first half-period after the fault latches, and it is 0 when no fault is latched.
- R9: While `uv_flag` is high, `gate_on` is 0. When the flag falls, `gate_on` follows the input again without any clearing step, and no fault is latched.
- R10: Fault flags raised while the block is asleep are ignored. `flt_oc` and `flt_ot` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timing enable; all intervals count these |
| pwm_in | input | 1 | Digitised level of the command/diagnostic line (asynchronous) |
| oc_flag | input | 1 | Over-current comparator flag (asynchronous) |
| ot_flag | input | 1 | Over-temperature comparator flag (asynchronous) |
| uv_flag | input | 1 | Supply-low comparator flag (asynchronous) |
| gate_on | output | 1 | Command to the gate driver |
| hard_off | output | 1 | Selects the immediate turn-off path; high while a fault is latched |
| diag_pull | output | 1 | Pull-down of the command line carrying the fault square wave |
| asleep | output | 1 | Low-power state indicator |
| flt_oc | output | 1 | Latched over-current status |
| flt_ot | output | 1 | Latched over-temperature status |

## Verification
The bench wakes the block with the tick enable held off. A design that counted clock cycles instead of ticks would release the gate early. It then interrupts a long low period just before the sleep limit, where an off-by-one or a counter that is not cleared on a high level would put the block to sleep too soon. The fault sequence wakes the block partway through the sleep reset interval: a design that cleared faults on sleep entry, or on wake, would let the gate turn back on. The sequence also changes the fault type while the square wave is running, and measures the half-period before and after, which catches a wrong priority or a divider that does not pick up the new limit.

// File: rtl/psw_pkg.sv
package psw_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP = 2'd0,
    ST_POR   = 2'd1,
    ST_RUN   = 2'd2
  } psw_state_e;
endpackage

// File: rtl/psw_sync.sv
module psw_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= d[i];
        s2_q <= s1_q;
      end
    end
    assign q[i] = s2_q;
  end
endmodule

// File: rtl/psw_fault_latch.sv
module psw_fault_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         clr,
  input  logic [N-1:0] set,
  output logic [N-1:0] q
);
  logic [N-1:0] q_q, q_d;

  for (genvar i = 0; i < N; i++) begin : g_lat
    always_comb begin
      if (clr)                 q_d[i] = 1'b0;
      else if (arm && set[i])  q_d[i] = 1'b1;
      else                     q_d[i] = q_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= '0;
    else        q_q <= q_d;
  end

  assign q = q_q;
endmodule

// File: rtl/psw_diag.sv
module psw_diag #(
  parameter int OT_HALF_TICKS = 1923,
  parameter int OC_HALF_TICKS = 7143
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic flt_ot,
  input  logic flt_oc,
  output logic pull
);
  localparam int HMAX = (OT_HALF_TICKS > OC_HALF_TICKS) ? OT_HALF_TICKS : OC_HALF_TICKS;
  localparam int HW   = $clog2(HMAX + 1);
  localparam logic [HW-1:0] OT_LIM = HW'(OT_HALF_TICKS - 1);
  localparam logic [HW-1:0] OC_LIM = HW'(OC_HALF_TICKS - 1);

  logic [HW-1:0] cnt_q, cnt_d;
  logic          ph_q, ph_d;
  logic [HW-1:0] lim;
  logic          active;

  assign active = flt_ot | flt_oc;
  assign lim    = flt_ot ? OT_LIM : OC_LIM;

  always_comb begin
    cnt_d = cnt_q;
    ph_d  = ph_q;
    if (!active) begin
      cnt_d = '0;
      ph_d  = 1'b0;
    end else if (tick) begin
      if (cnt_q >= lim) begin
        cnt_d = '0;
        ph_d  = ~ph_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assign pull = active & ~ph_q;
endmodule

// File: rtl/psw_sleep_ctrl.sv
module psw_sleep_ctrl
  import psw_pkg::*;
#(
  parameter int SLEEP_TICKS   = 30000,
  parameter int POR_TICKS     = 8,
  parameter int RST_TICKS     = 50,
  parameter int OT_HALF_TICKS = 1923,
  parameter int OC_HALF_TICKS = 7143
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwm_in,
  input  logic oc_flag,
  input  logic ot_flag,
  input  logic uv_flag,
  output logic gate_on,
  output logic hard_off,
  output logic diag_pull,
  output logic asleep,
  output logic flt_oc,
  output logic flt_ot
);
  localparam int TMAX = (POR_TICKS > RST_TICKS) ? POR_TICKS : RST_TICKS;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int LW   = $clog2(SLEEP_TICKS + 1);
  localparam logic [TW-1:0] POR_LIM = TW'(POR_TICKS - 1);
  localparam logic [TW-1:0] RST_LIM = TW'(RST_TICKS - 1);
  localparam logic [TW-1:0] RST_END = TW'(RST_TICKS);
  localparam logic [LW-1:0] LOW_LIM = LW'(SLEEP_TICKS - 1);

  logic [3:0] sync_q;
  logic       in_s, oc_s, ot_s, uv_s;

  psw_sync #(.W(4)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({uv_flag, ot_flag, oc_flag, pwm_in}),
    .q    (sync_q)
  );
  assign {uv_s, ot_s, oc_s, in_s} = sync_q;

  psw_state_e    st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic [LW-1:0] low_q, low_d;
  logic          in_prev_q;
  logic          rise, low_expire, clr;
  logic [1:0]    flt;

  assign rise       = in_s & ~in_prev_q;
  assign low_expire = (st_q != ST_SLEEP) && !in_s && tick && (low_q == LOW_LIM);

  always_comb begin
    st_d  = st_q;
    tmr_d = tmr_q;
    clr   = 1'b0;
    if (st_q == ST_SLEEP || in_s) low_d = '0;
    else if (tick)                low_d = low_q + 1'b1;
    else                          low_d = low_q;

    unique case (st_q)
      ST_SLEEP: begin
        if (rise) begin
          st_d  = ST_POR;
          tmr_d = '0;
        end else if (tick && tmr_q != RST_END) begin
          tmr_d = tmr_q + 1'b1;
          clr   = (tmr_q == RST_LIM);
        end
      end
      ST_POR: begin
        if (low_expire) begin
          st_d  = ST_SLEEP;
          tmr_d = '0;
        end else if (tick) begin
          if (tmr_q == POR_LIM) st_d = ST_RUN;
          else                  tmr_d = tmr_q + 1'b1;
        end
      end
      ST_RUN: begin
        if (low_expire) begin
          st_d  = ST_SLEEP;
          tmr_d = '0;
        end
      end
      default: begin
        st_d  = ST_SLEEP;
        tmr_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_SLEEP;
      tmr_q     <= '0;
      low_q     <= '0;
      in_prev_q <= 1'b0;
    end else begin
      st_q      <= st_d;
      tmr_q     <= tmr_d;
      low_q     <= low_d;
      in_prev_q <= in_s;
    end
  end

  psw_fault_latch #(.N(2)) u_flt (
    .clk  (clk),
    .rst_n(rst_n),
    .arm  (st_q != ST_SLEEP),
    .clr  (clr),
    .set  ({ot_s, oc_s}),
    .q    (flt)
  );

  psw_diag #(
    .OT_HALF_TICKS(OT_HALF_TICKS),
    .OC_HALF_TICKS(OC_HALF_TICKS)
  ) u_diag (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .flt_ot(flt[1]),
    .flt_oc(flt[0]),
    .pull  (diag_pull)
  );

  assign flt_ot   = flt[1];
  assign flt_oc   = flt[0];
  assign hard_off = |flt;
  assign asleep   = (st_q == ST_SLEEP);
  assign gate_on  = (st_q == ST_RUN) & in_s & ~uv_s & ~(|flt);
endmodule

// File: rtl/psw_sleep_ctrl_chk.sv
module psw_sleep_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic gate_on,
  input logic asleep,
  input logic flt_oc,
  input logic flt_ot,
  input logic diag_pull,
  input logic in_s,
  input logic uv_s
);
  a_r2_wake_needs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(in_s));

  a_r3_no_gate_at_wake: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> !gate_on);

  a_r6_gate_off_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    gate_on |-> !asleep && !flt_oc && !flt_ot);

  a_r7_clear_only_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(flt_oc) || $fell(flt_ot)) |-> asleep);

  a_r8_pull_needs_fault: assert property (@(posedge clk) disable iff (!rst_n)
    diag_pull |-> (flt_oc || flt_ot));

  a_r9_uv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    uv_s |-> !gate_on);

  a_r10_no_latch_asleep: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flt_oc) || $rose(flt_ot)) |-> !$past(asleep));
endmodule

bind psw_sleep_ctrl psw_sleep_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .gate_on  (gate_on),
  .asleep   (asleep),
  .flt_oc   (flt_oc),
  .flt_ot   (flt_ot),
  .diag_pull(diag_pull),
  .in_s     (in_s),
  .uv_s     (uv_s)
);

// File: tb/psw_sleep_ctrl_tb.sv
module psw_sleep_ctrl_tb;
  localparam int SLP = 40;
  localparam int POR = 8;
  localparam int RST = 12;
  localparam int OTH = 5;
  localparam int OCH = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic pwm_in = 1'b0, oc_flag = 1'b0, ot_flag = 1'b0, uv_flag = 1'b0;
  logic gate_on, hard_off, diag_pull, asleep, flt_oc, flt_ot;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  psw_sleep_ctrl #(
    .SLEEP_TICKS(SLP), .POR_TICKS(POR), .RST_TICKS(RST),
    .OT_HALF_TICKS(OTH), .OC_HALF_TICKS(OCH)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwm_in(pwm_in),
    .oc_flag(oc_flag), .ot_flag(ot_flag), .uv_flag(uv_flag),
    .gate_on(gate_on), .hard_off(hard_off), .diag_pull(diag_pull),
    .asleep(asleep), .flt_oc(flt_oc), .flt_ot(flt_ot)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_asleep();
    for (int i = 0; i < 300 && !asleep; i++) @(negedge clk);
  endtask

  task automatic half_period(output int n);
    logic prev;
    prev = diag_pull;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      n++;
      if (diag_pull != prev) break;
    end
  endtask

  task automatic t_reset();
    cyc(3);
    chk("R1 asleep", asleep, 1);
    chk("R1 gate_on", gate_on, 0);
    chk("R1 hard_off", hard_off, 0);
    chk("R1 diag_pull", diag_pull, 0);
    chk("R1 faults", {flt_ot, flt_oc}, 0);
  endtask

  task automatic t_wake_por();
    tick = 1'b0;
    pwm_in = 1'b1;
    cyc(30);
    chk("R2 woke on edge", asleep, 0);
    chk("R3 held without ticks", gate_on, 0);
    tick = 1'b1;
    cyc(5);
    chk("R3 held during delay", gate_on, 0);
    cyc(10);
    chk("R3 released after delay", gate_on, 1);
  endtask

  task automatic t_follow();
    pwm_in = 1'b0; cyc(3);
    chk("R4 follows low", gate_on, 0);
    pwm_in = 1'b1; cyc(3);
    chk("R4 follows high", gate_on, 1);
  endtask

  task automatic t_short_low();
    pwm_in = 1'b0; cyc(SLP - 4);
    pwm_in = 1'b1; cyc(5);
    chk("R5 short low stays awake", asleep, 0);
    chk("R5 gate back after short low", gate_on, 1);
  endtask

  task automatic t_uv();
    uv_flag = 1'b1; cyc(3);
    chk("R9 uv blocks gate", gate_on, 0);
    uv_flag = 1'b0; cyc(3);
    chk("R9 gate resumes", gate_on, 1);
    chk("R9 no fault latched", {flt_ot, flt_oc}, 0);
  endtask

  task automatic t_sleep();
    pwm_in = 1'b0; cyc(SLP - 2);
    chk("R5 awake before limit", asleep, 0);
    cyc(7);
    chk("R5 asleep after limit", asleep, 1);
  endtask

  task automatic t_flags_asleep();
    oc_flag = 1'b1; ot_flag = 1'b1; cyc(10);
    chk("R10 oc ignored asleep", flt_oc, 0);
    chk("R10 ot ignored asleep", flt_ot, 0);
    chk("R10 no pull asleep", diag_pull, 0);
    oc_flag = 1'b0; ot_flag = 1'b0; cyc(4);
  endtask

  task automatic t_short_pulse();
    pwm_in = 1'b1; cyc(3);
    pwm_in = 1'b0; cyc(3);
    chk("R2 short pulse wakes", asleep, 0);
    wait_asleep();
    chk("R5 back asleep after pulse", asleep, 1);
  endtask

  task automatic t_fault();
    int n;
    pwm_in = 1'b1; cyc(POR + 6);
    chk("R4 gate on before fault", gate_on, 1);
    oc_flag = 1'b1; cyc(4);
    chk("R6 oc latched", flt_oc, 1);
    chk("R6 gate off", gate_on, 0);
    chk("R6 hard_off", hard_off, 1);
    oc_flag = 1'b0; cyc(5);
    chk("R6 oc stays latched", flt_oc, 1);
    chk("R6 gate stays off", gate_on, 0);
    half_period(n);
    half_period(n);
    chk("R8 oc half period", n, OCH);
    ot_flag = 1'b1; cyc(4);
    ot_flag = 1'b0;
    chk("R6 ot latched", flt_ot, 1);
    half_period(n);
    half_period(n);
    chk("R8 ot priority half period", n, OTH);
  endtask

  task automatic t_clear();
    pwm_in = 1'b0;
    wait_asleep();
    cyc(5);
    chk("R7 fault kept early in sleep", flt_oc, 1);
    pwm_in = 1'b1; cyc(3);
    pwm_in = 1'b0; cyc(4);
    chk("R7 early wake", asleep, 0);
    chk("R7 fault kept after early wake", flt_oc, 1);
    wait_asleep();
    cyc(RST + 3);
    chk("R7 oc cleared", flt_oc, 0);
    chk("R7 ot cleared", flt_ot, 0);
    chk("R8 pull idle without fault", diag_pull, 0);
    pwm_in = 1'b1; cyc(POR + 6);
    chk("R4 gate follows after clear", gate_on, 1);
  endtask

  initial begin
    cyc(2);
    rst_n = 1'b1;
    t_reset();
    t_wake_por();
    t_follow();
    t_short_low();
    t_uv();
    t_sleep();
    t_flags_asleep();
    t_short_pulse();
    t_fault();
    t_clear();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule